// File: doc/BRIEF.md
# ADC Conversion Packet Responder

This block is the device-side logic of an isolated monitoring converter that a host reaches over a byte-serial link. The host sends a configuration command byte. The block keeps that byte as its configuration register and starts conversions according to the mode bit inside it. Each finished conversion goes back to the host as a short packet. The packet first echoes the configuration byte that was in force when the conversion began, then sends the result split over a high byte and a low byte.

Two modes are available. In demand mode, each command starts exactly one conversion. In continuous mode, the block restarts the converter as soon as the previous result has been handed to the transmitter, and no further commands are needed. A build-time option selects the two-wire bus variant. In that variant every command must be preceded by the fixed device address 0xF0, and every reply packet starts with that same address byte.

The analog converter sits outside the block and is reached through a start/done handshake that carries a result word. The serial transceiver also sits outside and is reached through byte streams with valid/ready. The receive stream never applies back-pressure: `rx_ready` stays high, and a byte is taken on every cycle in which `rx_valid` is high. On the transmit stream, a byte is offered while `tx_valid` is high. It stays unchanged until the cycle in which `tx_ready` is also high, and only then does the next byte of the packet take its place.

Top module: `adc_pkt_resp`

## Requirements
- R1: After reset, `tx_valid` and `conv_start` are low and `rx_ready` is high. The reset configuration is 0x01 (demand mode), so no conversion starts until a command arrives.
- R2: An accepted command byte whose bit 0 is 1 selects demand mode. It is stored as the configuration and produces exactly one `conv_start` pulse, one cycle wide, in the cycle after the byte is accepted when the block is idle.
- R3: Each packet carries, in this order, the configuration byte, the high result byte and the low result byte. The 10-bit result is right-justified over the two result bytes: the high byte holds result bits 9..8 in its bits 1..0, and its upper bits are zero.
- R4: A command whose bit 0 is 0 selects continuous mode. In this mode a new conversion starts on its own, two cycles after each packet is handed to the transmitter, until a demand-mode command arrives.
- R5: The configuration byte echoed in a packet is the value that was in force when that packet's conversion started, even if a newer command arrives later.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value. Each byte advances only on a cycle in which both are high.
- R7: In the address variant, a command is accepted only when it follows the address byte 0xF0, and every reply packet starts with 0xF0 ahead of the configuration byte.
- R8: In the address variant, a command byte that follows any address other than 0xF0 is dropped. The configuration stays the same, so a running continuous mode keeps running and keeps echoing the old value, and in demand mode no conversion starts.
- R9: A demand-mode command that arrives while a conversion is in flight or its packet is still waiting is remembered. It starts one further conversion once the block is idle again.
- R10: At most one conversion is in flight: `conv_start` never pulses while an earlier conversion has not yet completed or its packet has not yet been handed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Always high, the block takes every byte |
| rx_data | input | 8 | Received byte (address or command) |
| tx_valid | output | 1 | Packet byte offered |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_data | output | 8 | Packet byte |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_done | input | 1 | One-cycle converter completion pulse |
| conv_result | input | RES_W | Converter result, valid with `conv_done` |

## Verification
The bench builds two copies side by side, both with a 10-bit result. One has the address option off and produces 3-byte packets. The other has the address option on and produces 4-byte packets that start with 0xF0. The address copy is the only one that can reach the mismatched-address drop. It is also the only one where a second command reaches the block two cycles later and finds it busy. Converter latency and transmit back-pressure are both random. This lets commands land during conversion, during the waiting packet and in the middle of transmission, which brings the echo-snapshot and queued-demand cases within reach.

// File: rtl/adc_pkt_pkg.sv
package adc_pkt_pkg;

  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_BUSY = 2'd1,
    CV_HOLD = 2'd2
  } cv_state_t;

  localparam logic [7:0] DEV_ADDR_DEFAULT = 8'hF0;
  localparam logic [7:0] CFG_RESET_DEFAULT = 8'h01;

endpackage

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx #(
  parameter bit         ADDR_EN  = 1'b0,
  parameter logic [7:0] ADDR_VAL = 8'hF0,
  parameter logic [7:0] CFG_RST  = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       cmd_wr,
  output logic [7:0] cmd_byte,
  output logic [7:0] cfg_q
);

  logic take;

  assign rx_ready = 1'b1;
  assign take     = rx_valid & rx_ready;
  assign cmd_byte = rx_data;

  generate
    if (ADDR_EN) begin : g_addr
      logic phase_q;
      logic match_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          phase_q <= 1'b0;
          match_q <= 1'b0;
        end else if (take) begin
          phase_q <= ~phase_q;
          if (!phase_q) match_q <= (rx_data == ADDR_VAL);
        end
      end

      assign cmd_wr = take & phase_q & match_q;

      // R8: a command after a foreign address leaves the configuration alone
      a_r8_foreign_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (take && phase_q && !match_q) |=> $stable(cfg_q));
    end else begin : g_plain
      assign cmd_wr = take;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cmd_wr) cfg_q <= cmd_byte;
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_pkt_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int MODE_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       cfg_q,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_cfg,
  output logic [RES_W-1:0] pkt_res
);

  cv_state_t  state_q;
  logic       pend_q;
  logic [7:0] cfg_next;
  logic       demand_next;
  logic       demand_cmd;
  logic       start_req;

  assign cfg_next    = cmd_wr ? cmd_byte : cfg_q;
  assign demand_next = cfg_next[MODE_POS];
  assign demand_cmd  = cmd_wr & cmd_byte[MODE_POS];
  assign start_req   = pend_q | ~demand_next | demand_cmd;
  assign pkt_valid   = (state_q == CV_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= CV_IDLE;
      pend_q     <= 1'b0;
      conv_start <= 1'b0;
      pkt_cfg    <= '0;
      pkt_res    <= '0;
    end else begin
      conv_start <= 1'b0;
      if (demand_cmd && state_q != CV_IDLE) pend_q <= 1'b1;
      unique case (state_q)
        CV_IDLE: begin
          if (start_req) begin
            conv_start <= 1'b1;
            pkt_cfg    <= cfg_next;
            pend_q     <= 1'b0;
            state_q    <= CV_BUSY;
          end
        end
        CV_BUSY: begin
          if (conv_done) begin
            pkt_res <= conv_result;
            state_q <= CV_HOLD;
          end
        end
        CV_HOLD: begin
          if (pkt_ready) state_q <= CV_IDLE;
        end
        default: state_q <= CV_IDLE;
      endcase
    end
  end

  // R2: the start strobe lasts one cycle
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10: no start while a result waits for the transmitter
  a_r10_no_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CV_HOLD) |-> !conv_start);

  // R4: continuous mode restarts two cycles after hand-off
  a_r4_burst_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CV_HOLD && pkt_ready && !cfg_q[MODE_POS]) |=> ##1 conv_start);

  // R5: the echoed configuration does not move while a conversion is in flight
  a_r5_echo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CV_BUSY) |=> $stable(pkt_cfg));

endmodule

// File: rtl/adc_pkt_tx.sv
module adc_pkt_tx #(
  parameter int         RES_W    = 10,
  parameter bit         ADDR_EN  = 1'b0,
  parameter logic [7:0] ADDR_VAL = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [7:0]       pkt_cfg,
  input  logic [RES_W-1:0] pkt_res,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data
);

  localparam int NB    = ADDR_EN ? 4 : 3;
  localparam int FW    = NB * 8;
  localparam int CNT_W = $clog2(NB + 1);

  logic [15:0]      res_ext;
  logic [FW-1:0]    frame_w;
  logic [FW-1:0]    frame_q;
  logic [CNT_W-1:0] left_q;
  logic             load;
  logic             step;

  assign res_ext = 16'(pkt_res);

  generate
    if (ADDR_EN) begin : g_addr_frame
      assign frame_w = {ADDR_VAL, pkt_cfg, res_ext[15:8], res_ext[7:0]};
    end else begin : g_plain_frame
      assign frame_w = {pkt_cfg, res_ext[15:8], res_ext[7:0]};
    end
  endgenerate

  assign tx_valid  = (left_q != '0);
  assign pkt_ready = ~tx_valid;
  assign tx_data   = frame_q[FW-1 -: 8];
  assign load      = pkt_valid & pkt_ready;
  assign step      = tx_valid & tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      frame_q <= '0;
    end else if (load) begin
      left_q  <= CNT_W'(NB);
      frame_q <= frame_w;
    end else if (step) begin
      left_q  <= left_q - 1'b1;
      frame_q <= {frame_q[FW-9:0], 8'h00};
    end
  end

  // R6: an offered byte holds under back-pressure
  a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  generate
    if (ADDR_EN) begin : g_addr_chk
      // R7: a reply opens with the device address
      a_r7_addr_leads: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tx_valid && tx_data == ADDR_VAL));
    end
  endgenerate

endmodule

// File: rtl/adc_pkt_resp.sv
module adc_pkt_resp
  import adc_pkt_pkg::*;
#(
  parameter int         RES_W    = 10,
  parameter bit         ADDR_EN  = 1'b0,
  parameter logic [7:0] ADDR_VAL = DEV_ADDR_DEFAULT,
  parameter logic [7:0] CFG_RST  = CFG_RESET_DEFAULT,
  parameter int         MODE_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);

  logic             cmd_wr;
  logic [7:0]       cmd_byte;
  logic [7:0]       cfg_q;
  logic             pkt_valid;
  logic             pkt_ready;
  logic [7:0]       pkt_cfg;
  logic [RES_W-1:0] pkt_res;

  adc_cmd_rx #(
    .ADDR_EN (ADDR_EN),
    .ADDR_VAL(ADDR_VAL),
    .CFG_RST (CFG_RST)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ready(rx_ready),
    .cmd_wr  (cmd_wr),
    .cmd_byte(cmd_byte),
    .cfg_q   (cfg_q)
  );

  adc_conv_ctrl #(
    .RES_W   (RES_W),
    .MODE_POS(MODE_POS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_byte   (cmd_byte),
    .cfg_q      (cfg_q),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_result(conv_result),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_cfg    (pkt_cfg),
    .pkt_res    (pkt_res)
  );

  adc_pkt_tx #(
    .RES_W   (RES_W),
    .ADDR_EN (ADDR_EN),
    .ADDR_VAL(ADDR_VAL)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready),
    .pkt_cfg  (pkt_cfg),
    .pkt_res  (pkt_res),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );

endmodule

// File: tb/tb_adc_pkt_resp.sv
module tb_adc_pkt_resp;

  localparam int RES_W = 10;
  localparam logic [7:0] ADDR = 8'hF0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             rx_valid    [2];
  logic [7:0]       rx_data     [2];
  logic             rx_ready    [2];
  logic             tx_valid    [2];
  logic             tx_ready    [2];
  logic [7:0]       tx_data     [2];
  logic             conv_start  [2];
  logic             conv_done   [2];
  logic [RES_W-1:0] conv_result [2];

  int         n_chk = 0;
  int         n_err = 0;
  int         starts [2];
  int         rdy_pct = 70;
  logic [7:0] cfg_m [2];
  bit         fin = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  for (genvar v = 0; v < 2; v++) begin : g_var
    localparam int NB = 3 + v;
    logic [17:0] exp_q [$];

    adc_pkt_resp #(.RES_W(RES_W), .ADDR_EN(v == 1)) dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid[v]), .rx_ready(rx_ready[v]), .rx_data(rx_data[v]),
      .tx_valid(tx_valid[v]), .tx_ready(tx_ready[v]), .tx_data(tx_data[v]),
      .conv_start(conv_start[v]), .conv_done(conv_done[v]),
      .conv_result(conv_result[v])
    );

    // converter model
    initial begin
      int cnt = 0;
      logic [RES_W-1:0] r = '0;
      conv_done[v] = 1'b0;
      conv_result[v] = '0;
      forever begin
        @(negedge clk);
        conv_done[v] = 1'b0;
        if (!rst_n) cnt = 0;
        else begin
          if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
              conv_done[v] = 1'b1;
              conv_result[v] = r;
            end
          end
          if (conv_start[v]) begin
            check(cnt == 0 && !conv_done[v], "R10", "start while converting", cnt, 0);
            starts[v]++;
            r = RES_W'($urandom);
            cnt = 1 + int'($urandom % 10);
            exp_q.push_back({cfg_m[v], r});
          end
        end
      end
    end

    // transmit monitor
    initial begin
      logic [7:0] got [4];
      int nb = 0;
      bit hold_v = 0;
      logic [7:0] hold_d = '0;
      logic [17:0] e;
      tx_ready[v] = 1'b0;
      forever begin
        @(negedge clk);
        if (!rst_n) begin
          nb = 0; hold_v = 0; tx_ready[v] = 1'b0;
        end else begin
          if (hold_v)
            check(tx_valid[v] && tx_data[v] == hold_d, "R6", "held byte",
                  {tx_valid[v], tx_data[v]}, {1'b1, hold_d});
          tx_ready[v] = (int'($urandom % 100) < rdy_pct);
          hold_v = tx_valid[v] && !tx_ready[v];
          hold_d = tx_data[v];
          if (tx_valid[v] && tx_ready[v]) begin
            got[nb] = tx_data[v];
            nb++;
            if (nb == NB) begin
              nb = 0;
              if (exp_q.size() == 0)
                check(0, "R2", "unexpected packet", got[NB-3], 0);
              else begin
                e = exp_q.pop_front();
                if (v == 1) check(got[0] == ADDR, "R7", "reply address", got[0], ADDR);
                check(got[NB-3] == e[17:10], "R5", "echoed cfg", got[NB-3], e[17:10]);
                check(got[NB-2] == {6'b0, e[9:8]}, "R3", "high byte", got[NB-2], {6'b0, e[9:8]});
                check(got[NB-1] == e[7:0], "R3", "low byte", got[NB-1], e[7:0]);
              end
            end
          end
        end
      end
    end
  end

  function automatic int qsize(input int v);
    return (v == 0) ? g_var[0].exp_q.size() : g_var[1].exp_q.size();
  endfunction

  task automatic put_byte(input int v, input logic [7:0] b);
    @(negedge clk);
    rx_valid[v] = 1'b1;
    rx_data[v] = b;
    @(posedge clk);
    #1;
    rx_valid[v] = 1'b0;
  endtask

  task automatic send(input int v, input logic [7:0] addr, input logic [7:0] cmd);
    if (v == 1) put_byte(v, addr);
    put_byte(v, cmd);
    if (v == 0 || addr == ADDR) cfg_m[v] = cmd;
  endtask

  task automatic drain(input int v);
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 25; i++) begin
      @(negedge clk);
      if (qsize(v) == 0 && !tx_valid[v]) quiet++;
      else quiet = 0;
    end
    check(qsize(v) == 0, "R3", "packets outstanding after drain", qsize(v), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    for (int v = 0; v < 2; v++) begin
      rx_valid[v] = 1'b0; rx_data[v] = '0; starts[v] = 0; cfg_m[v] = 8'h01;
    end
    repeat (5) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check(!tx_valid[v] && !conv_start[v] && rx_ready[v], "R1", "reset outputs",
            {tx_valid[v], conv_start[v], rx_ready[v]}, 3'b001);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    for (int v = 0; v < 2; v++)
      check(starts[v] == 0 && !tx_valid[v], "R1", "idle after reset", starts[v], 0);

    for (int v = 0; v < 2; v++) begin
      // R2: one demand command, one conversion
      s0 = starts[v];
      send(v, ADDR, 8'h01);
      drain(v);
      check(starts[v] == s0 + 1, "R2", "starts per demand cmd", starts[v] - s0, 1);

      // R9: second demand while busy is queued
      s0 = starts[v];
      send(v, ADDR, 8'h01);
      send(v, ADDR, 8'h81);
      drain(v);
      check(starts[v] == s0 + 2, "R9", "queued demand", starts[v] - s0, 2);

      // R5: new command during slow transmission
      rdy_pct = 10;
      s0 = starts[v];
      send(v, ADDR, 8'h11);
      for (int i = 0; i < 200 && !tx_valid[v]; i++) @(negedge clk);
      send(v, ADDR, 8'h45);
      drain(v);
      rdy_pct = 70;
      check(starts[v] == s0 + 2, "R5", "starts around mid-packet cmd", starts[v] - s0, 2);

      // R4: continuous mode
      s0 = starts[v];
      send(v, ADDR, 8'h00);
      repeat (200) @(negedge clk);
      check(starts[v] - s0 >= 4, "R4", "burst conversions", starts[v] - s0, 4);
      send(v, ADDR, 8'h01);
      drain(v);
      s0 = starts[v];
      repeat (40) @(negedge clk);
      check(starts[v] == s0, "R4", "burst stops after demand cmd", starts[v] - s0, 0);
    end

    // R8: foreign address while in burst
    send(1, ADDR, 8'h00);
    repeat (30) @(negedge clk);
    s0 = starts[1];
    send(1, 8'h3C, 8'h01);
    repeat (150) @(negedge clk);
    check(starts[1] - s0 >= 3, "R8", "burst survives foreign cmd", starts[1] - s0, 3);
    send(1, ADDR, 8'h01);
    drain(1);
    // R8: foreign address in demand mode
    s0 = starts[1];
    send(1, 8'h12, 8'h01);
    repeat (40) @(negedge clk);
    check(starts[1] == s0 && !tx_valid[1], "R8", "no conversion on foreign cmd", starts[1] - s0, 0);
    // R7: matching address accepted
    send(1, ADDR, 8'h03);
    drain(1);
    check(starts[1] == s0 + 1, "R7", "matching address accepted", starts[1] - s0, 1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      for (int v = 0; v < 2; v++) begin
        logic [7:0] cmd;
        logic [7:0] ad;
        cmd = 8'($urandom);
        if ($urandom % 5 != 0) cmd[0] = 1'b1;
        ad = ($urandom % 8 == 0) ? 8'($urandom % 240) : ADDR;
        rdy_pct = 20 + int'($urandom % 80);
        send(v, ad, cmd);
        repeat (int'($urandom % 40)) @(negedge clk);
      end
    end
    for (int v = 0; v < 2; v++) begin
      send(v, ADDR, 8'h01);
      drain(v);
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule